// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Tick Generator

This block derives the two timing enables an asynchronous serial port needs from a fast system clock. The receiver gets an oversample tick and the transmitter gets a bit tick. Both are single-cycle pulses that the port logic uses as clock enables, so the port runs entirely in the system clock domain.

The rate is set by a 12-bit divisor. Software loads it as two byte-wide writes over a small register interface. A down-counter, reloaded from the divisor each time it reaches zero, produces one oversample tick every divisor+1 clocks. A phase counter then groups these oversample ticks into bit periods of 16 ticks, or of 8 ticks when the double-speed input is set. With a 16 MHz system clock and a divisor of 16, the bit period is 272 clocks, or about 58.8 kbit/s. That is the usual setting for a nominal 57600 bit/s link.

The upper divisor bits are held in a staging register until the lower byte arrives. Writing the lower byte commits the whole value and restarts the count at once, so the new rate applies from the write onward.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 0. The oversample tick is therefore high on every clock, and the bit tick fires on every 16th clock, counting the clock in which reset is released as the first.
- R2: With committed divisor D, the oversample tick is a one-clock pulse that repeats every D+1 clocks.
- R3: A write with `wr_sel`=0 (low byte) commits the divisor as {staged high nibble, `wr_data`} and restarts the count at once. The first oversample tick comes D+1 clocks after the write edge, and the first bit tick comes N·(D+1) clocks after it, where N is the current ratio.
- R4: A write with `wr_sel`=1 (high byte) only updates the staging register. The tick rates stay unchanged until the next low-byte write.
- R5: With `dbl_speed`=0, the bit tick fires on every 16th oversample tick, always in the same clock as an oversample tick, so its period is 16·(D+1) clocks.
- R6: With `dbl_speed`=1, the bit tick fires on every 8th oversample tick, so its period is 8·(D+1) clocks.
- R7: A divisor of 16 in normal-speed mode gives a bit period of 272 clocks.
- R8: A high-byte write takes only `wr_data[3:0]` as divisor bits 11:8. `wr_data[7:4]` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = low divisor byte (commit and reload), 1 = high divisor byte (stage) |
| wr_data | input | 8 | Write data |
| dbl_speed | input | 1 | 1 selects 8 oversample ticks per bit, 0 selects 16 |
| os_tick | output | 1 | Receiver oversample enable, one clock wide |
| bit_tick | output | 1 | Transmitter bit enable, one clock wide |

## Verification
Every divisor from 0 to 20 is tried in both speed modes. Each run measures three things: the latency to the first oversample tick, the latency to the first bit tick, and the following bit period. The latencies separate a true reload-on-write from a counter that waits for its next zero. The bit period separates the 16 and 8 ratios. A high-nibble value with its upper data bits set tests staging and masking. A high-byte write with no low-byte write after it shows that the rate does not move. The divisor-16 case confirms the standard 57600 bit/s setting.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } div_sel_e;

  // oversample ticks per bit for the selected speed
  function automatic int unsigned ratio_for(input logic dbl, input int unsigned n_norm,
                                            input int unsigned n_dbl);
    return dbl ? n_dbl : n_norm;
  endfunction

  // clocks between oversample ticks for a divisor
  function automatic int unsigned os_period(input int unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_tick_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DIV_W-1:0]  divisor,
  output logic              load,
  output logic [DIV_W-1:0]  load_val
);

  logic [DATA_W-1:0] hi_stage;
  logic              hi_wr;

  assign hi_wr    = wr_en && (div_sel_e'(wr_sel) == SEL_HI);
  assign load     = wr_en && (div_sel_e'(wr_sel) == SEL_LO);
  assign load_val = DIV_W'({hi_stage, wr_data});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage <= '0;
      divisor  <= '0;
    end else begin
      if (hi_wr) hi_stage <= wr_data;
      if (load)  divisor  <= load_val;
    end
  end

  AST_HI_ONLY_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> $stable(divisor)); // R4

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             os_tick
);

  logic [DIV_W-1:0] cnt;
  logic             underflow;

  assign underflow = (cnt == '0);
  assign os_tick   = underflow;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (underflow) cnt <= divisor;
    else                cnt <= cnt - 1'b1;
  end

  AST_RELOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R3
  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !load) |=> (cnt == divisor)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= divisor); // R2

endmodule

// File: rtl/baud_os_divider.sv
module baud_os_divider
  import baud_tick_pkg::*;
#(
  parameter int OS_NORM = 16,
  parameter int OS_DBL  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic dbl_speed,
  input  logic os_tick,
  output logic bit_tick
);

  localparam int PH_W = (OS_NORM > 1) ? $clog2(OS_NORM) : 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last_phase;
  logic            wrap;

  assign last_phase = PH_W'(ratio_for(dbl_speed, OS_NORM, OS_DBL) - 1);
  assign wrap       = (phase >= last_phase);
  assign bit_tick   = os_tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (clear)   phase <= '0;
    else if (os_tick) phase <= wrap ? '0 : phase + 1'b1;
  end

  AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick); // R5
  AST_CLEAR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (phase == '0)); // R3
  AST_BIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !clear) |=> (phase == '0)); // R6

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W   = 12,
  parameter int DATA_W  = 8,
  parameter int OS_NORM = 16,
  parameter int OS_DBL  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbl_speed,
  output logic              os_tick,
  output logic              bit_tick
);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] load_val;
  logic             load;

  baud_div_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .divisor(divisor), .load(load), .load_val(load_val)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .load(load),
    .load_val(load_val), .os_tick(os_tick)
  );

  baud_os_divider #(.OS_NORM(OS_NORM), .OS_DBL(OS_DBL)) u_osd (
    .clk(clk), .rst_n(rst_n), .clear(load), .dbl_speed(dbl_speed),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       dbl_speed = 1'b0;
  logic       os_tick, bit_tick;

  int total = 0;
  int bad   = 0;
  localparam int LIMIT = 20000;

  always #10 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dbl_speed(dbl_speed), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // clocks until the next bit tick, starting at the next negedge
  task automatic next_bit(output int p);
    p = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk); p++;
      if (bit_tick) break;
    end
  endtask

  // called at the first negedge after a restart (k = 1)
  task automatic measure(input int d, input int n, input string req);
    int k, first_os, first_bit, n_os, per;
    k = 0; first_os = 0; first_bit = 0; n_os = 0;
    for (int i = 0; i < LIMIT; i++) begin
      if (i != 0) @(negedge clk);
      k++;
      if (os_tick) begin
        if (first_os == 0) first_os = k;
        n_os++;
      end
      if (bit_tick) begin first_bit = k; break; end
    end
    check({req, " first os tick"}, first_os, d + 1);
    check({req, " first bit tick"}, first_bit, n * (d + 1));
    check({req, " os ticks per bit"}, n_os, n);
    next_bit(per);
    check({req, " bit period"}, per, n * (d + 1));
  endtask

  initial begin
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset divisor 0, ratio 16
    measure(0, 16, "R1 reset");

    // R2 R3 R5 R6: sweep small divisors in both speeds
    for (int dbl = 0; dbl < 2; dbl++) begin
      for (int d = 0; d <= 20; d++) begin
        dbl_speed = dbl[0];
        wr(1'b1, 8'h00);
        wr(1'b0, d[7:0]);
        measure(d, dbl ? 8 : 16, dbl ? "R6 R3 sweep" : "R5 R2 sweep");
      end
    end

    // R7: divisor 16 normal speed
    dbl_speed = 1'b0;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd16);
    measure(16, 16, "R7 divisor16");
    check("R7 bit period 272", 16 * 17, 272);

    // R8: upper nibble of high byte ignored -> divisor 0x105
    wr(1'b1, 8'hF1);
    wr(1'b0, 8'h05);
    measure(261, 16, "R8 high nibble");

    // R4: high write alone leaves the rate untouched
    wr(1'b1, 8'h03);
    next_bit(per);
    next_bit(per);
    check("R4 staged only", per, 16 * 262);

    // R3 R6: commit of staged 0x3 with low 0x00 in double speed
    dbl_speed = 1'b1;
    wr(1'b0, 8'h00);
    measure(768, 8, "R3 R6 commit staged");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule